// File: doc/BRIEF.md
# DMA Width-Converting Byte Packer

This block is the datapath between the read side and the write side of one DMA channel. Source beats arrive on a 32-bit bus as 8-, 16- or 32-bit quantities. The block turns each beat into an ordered run of bytes, using the beat's low address bits and the source byte order. It then groups those bytes into destination beats of 8, 16 or 32 bits, laid out in the destination byte order. When the two sides use different byte orders, the bytes inside each 32-bit word come out reversed. When both sides use the same order, the bytes keep their positions.

A `start` pulse latches the two widths, the two byte orders and the transfer length in bytes. Source beats are then taken over a valid/ready handshake until the length has been consumed. Destination beats leave over a second valid/ready handshake. A narrow destination value is copied onto every matching slot of the bus, and its byte strobe is copied the same way. If the length ends partway through a destination beat, that last beat carries a strobe covering only the bytes that exist. A stalled destination holds its beat and, through a small byte queue, eventually stalls the source side.

Top module: `dma_lane_packer`

## Requirements
- R1: While reset is high and in the first cycle after it, `dst_valid` and `src_ready` are 0.
- R2: Width codes (00 = 8 bit, 01 = 16 bit, 10 = 32 bit), byte-order flags (0 = little, 1 = big) and the byte length are captured only in a cycle with `start` high. Changes to those inputs during a transfer do not alter the beats produced.
- R3: Little-endian source: stream byte k of a beat of width SW bytes at low address A is read from lane (A+k) mod 4, where lane n is bits [8n+7:8n].
- R4: Big-endian source: stream byte k is read from lane 3-((A+k) mod 4).
- R5: Little-endian destination: value byte j of a DW-byte beat is stream byte j of that beat. For example, bytes 21,43,65,87 into a 32-bit beat give 0x87654321.
- R6: Big-endian destination: value byte j is stream byte DW-1-j. With opposite byte orders on the two sides, a 32-bit word is byte-reversed (0x87654321 becomes 0x21436587).
- R7: A 16-bit destination value is driven on both bus halves, and an 8-bit value on all four lanes (0x4321 gives 0x43214321, 0x21 gives 0x21212121). The strobe is copied with the same pattern.
- R8: Exactly the programmed number of bytes is accepted. A source beat that reaches past the end contributes only its leading bytes, and once the count is used up `src_ready` stays 0.
- R9: A destination beat that the remaining bytes cannot fill is issued with a strobe marking only the lanes that hold real bytes (3 bytes into 32-bit: 0111 little, 1110 big; 1 byte into 16-bit: 0101 little). All beats that are not last carry strobe 1111.
- R10: While `dst_valid` is high and `dst_ready` is low, the beat holds its data and strobe. Back-pressure never loses, duplicates or reorders a byte, and the internal byte queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a transfer; captures configuration and flushes the queue |
| cfg_src_w | input | 2 | Source beat width code |
| cfg_dst_w | input | 2 | Destination beat width code |
| cfg_src_be | input | 1 | Source byte order, 1 = big-endian |
| cfg_dst_be | input | 1 | Destination byte order, 1 = big-endian |
| cfg_len | input | LEN_W | Transfer length in bytes |
| src_valid | input | 1 | Source beat present |
| src_ready | output | 1 | Source beat accepted this cycle when valid |
| src_addr | input | 2 | Low byte-address bits of the source beat |
| src_data | input | 32 | Source bus data |
| dst_valid | output | 1 | Destination beat present |
| dst_ready | input | 1 | Write side takes the beat |
| dst_data | output | 32 | Destination data, lane-replicated |
| dst_strb | output | 4 | Byte strobe of the destination beat |

## Verification
A wrong queue occupancy or read pointer shows at the ports on the very next destination beat. That beat carries a byte from the wrong place in the stream, a stale byte, or a strobe of the wrong shape. A wrong remaining-byte count shows instead at the end of the transfer: either `src_ready` stays high after the last byte, or a short beat appears before the end. A wrong lane mapping changes the first beat of any transfer that uses the affected width and byte order. For that reason the stimulus sweeps every combination of widths, byte orders, starting offsets and lengths, and throttles both handshakes at random.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    typedef enum logic [1:0] {
        WID_8  = 2'b00,
        WID_16 = 2'b01,
        WID_32 = 2'b10
    } wid_e;

    typedef struct packed {
        wid_e src_w;
        wid_e dst_w;
        logic src_be;
        logic dst_be;
    } xfer_cfg_t;

    // Bytes carried by one beat of the given width code (reserved code acts as widest).
    function automatic int unsigned wid_bytes(input wid_e w);
        case (w)
            WID_8:   return 1;
            WID_16:  return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/dlp_src_unpack.sv
// Pulls the stream-ordered bytes out of one source beat.
module dlp_src_unpack #(
    parameter int NB = 4,
    parameter int AW = 2
) (
    input  logic [NB-1:0][7:0] beat,
    input  logic [AW-1:0]      addr,
    input  logic               big_end,
    output logic [NB-1:0][7:0] bytes_o
);
    for (genvar k = 0; k < NB; k++) begin : g_byte
        logic [AW-1:0] lane;
        always_comb begin
            lane = addr + AW'(k);
            if (big_end) lane = ~lane;
            bytes_o[k] = beat[lane];
        end
    end
endmodule

// File: rtl/dlp_byte_queue.sv
// Shift queue of bytes: pops from the head and appends in the same cycle.
module dlp_byte_queue #(
    parameter int NB = 4,
    parameter int QD = 8,
    parameter int OW = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic [OW-1:0]      push_n,
    input  logic [NB-1:0][7:0] push_b,
    input  logic [OW-1:0]      pop_n,
    output logic [NB-1:0][7:0] head,
    output logic [OW-1:0]      occ
);
    localparam int IW  = $clog2(QD);
    localparam int PIW = $clog2(NB);

    logic [QD-1:0][7:0] mem, mem_n;
    logic [OW-1:0]      occ_n;

    always_comb begin
        for (int i = 0; i < QD; i++) begin
            logic [OW:0] s;
            logic [OW:0] t;
            s = (OW+1)'(i) + {1'b0, pop_n};
            t = s - {1'b0, occ};
            if (s < {1'b0, occ})
                mem_n[i] = mem[s[IW-1:0]];
            else if (t < {1'b0, push_n})
                mem_n[i] = push_b[t[PIW-1:0]];
            else
                mem_n[i] = 8'h00;
        end
        occ_n = occ - pop_n + push_n;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            mem <= '0;
            occ <= '0;
        end else begin
            mem <= mem_n;
            occ <= occ_n;
        end
    end

    for (genvar h = 0; h < NB; h++) begin : g_head
        assign head[h] = mem[h];
    end
endmodule

// File: rtl/dlp_dst_pack.sv
// Lays queue-head bytes onto the destination lanes with replication and strobe.
module dlp_dst_pack #(
    parameter int NB = 4,
    parameter int AW = 2,
    parameter int CW = 3,
    parameter int OW = 4
) (
    input  logic [NB-1:0][7:0] head,
    input  logic [CW-1:0]      dw,
    input  logic [OW-1:0]      avail,
    input  logic               big_end,
    output logic [NB-1:0][7:0] data_o,
    output logic [NB-1:0]      strb_o
);
    logic [AW-1:0] dw_m1;
    assign dw_m1 = AW'(dw - CW'(1));

    for (genvar l = 0; l < NB; l++) begin : g_lane
        logic [AW-1:0] j;
        logic [AW-1:0] si;
        always_comb begin
            j  = AW'(l) & dw_m1;
            si = big_end ? (dw_m1 - j) : j;
            data_o[l] = head[si];
            strb_o[l] = (OW'(si) < avail);
        end
    end
endmodule

// File: rtl/dma_lane_packer.sv
module dma_lane_packer
    import dlp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [1:0]               cfg_src_w,
    input  logic [1:0]               cfg_dst_w,
    input  logic                     cfg_src_be,
    input  logic                     cfg_dst_be,
    input  logic [LEN_W-1:0]         cfg_len,
    input  logic                     src_valid,
    output logic                     src_ready,
    input  logic [$clog2(DATA_W/8)-1:0] src_addr,
    input  logic [DATA_W-1:0]        src_data,
    output logic                     dst_valid,
    input  logic                     dst_ready,
    output logic [DATA_W-1:0]        dst_data,
    output logic [DATA_W/8-1:0]      dst_strb
);
    localparam int NB = DATA_W / 8;
    localparam int AW = $clog2(NB);
    localparam int CW = $clog2(NB + 1);
    localparam int QD = 2 * NB;
    localparam int OW = $clog2(QD + 1);

    function automatic logic [CW-1:0] beat_bytes(input wid_e w);
        int unsigned b;
        b = wid_bytes(w);
        if (b > NB) b = NB;
        return CW'(b);
    endfunction

    xfer_cfg_t          cfg_q;
    logic [LEN_W-1:0]   src_left;
    logic [CW-1:0]      sw, dw, take;
    logic [OW-1:0]      occ, push_n, pop_n, avail;
    logic               room, src_fire, dst_fire, out_full, out_tail;
    logic [NB-1:0][7:0] src_bytes, head, pack_data;
    logic [NB-1:0]      pack_strb;

    // Configuration and byte budget.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            src_left <= '0;
        end else if (start) begin
            cfg_q.src_w  <= wid_e'(cfg_src_w);
            cfg_q.dst_w  <= wid_e'(cfg_dst_w);
            cfg_q.src_be <= cfg_src_be;
            cfg_q.dst_be <= cfg_dst_be;
            src_left     <= cfg_len;
        end else if (src_fire) begin
            src_left <= src_left - LEN_W'(take);
        end
    end

    always_comb begin
        sw   = beat_bytes(cfg_q.src_w);
        dw   = beat_bytes(cfg_q.dst_w);
        take = (src_left < LEN_W'(sw)) ? CW'(src_left) : sw;
        room = ({1'b0, occ} + (OW+1)'(take)) <= (OW+1)'(QD);
    end

    // Handshakes.
    assign src_ready = !start && (src_left != '0) && room;
    assign src_fire  = src_valid && src_ready;
    assign out_full  = occ >= OW'(dw);
    assign out_tail  = (src_left == '0) && (occ != '0);
    assign dst_valid = !start && (out_full || out_tail);
    assign dst_fire  = dst_valid && dst_ready;
    assign avail     = out_full ? OW'(dw) : occ;
    assign push_n    = src_fire ? OW'(take) : '0;
    assign pop_n     = dst_fire ? avail : '0;

    dlp_src_unpack #(.NB(NB), .AW(AW)) u_unpack (
        .beat    (src_data),
        .addr    (src_addr),
        .big_end (cfg_q.src_be),
        .bytes_o (src_bytes)
    );

    dlp_byte_queue #(.NB(NB), .QD(QD), .OW(OW)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .push_n (push_n),
        .push_b (src_bytes),
        .pop_n  (pop_n),
        .head   (head),
        .occ    (occ)
    );

    dlp_dst_pack #(.NB(NB), .AW(AW), .CW(CW), .OW(OW)) u_pack (
        .head    (head),
        .dw      (dw),
        .avail   (avail),
        .big_end (cfg_q.dst_be),
        .data_o  (pack_data),
        .strb_o  (pack_strb)
    );

    assign dst_data = pack_data;
    assign dst_strb = pack_strb;
endmodule

// File: rtl/dlp_checker.sv
module dlp_checker #(
    parameter int NB    = 4,
    parameter int QD    = 8,
    parameter int OW    = 4,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             src_ready,
    input logic             dst_valid,
    input logic             dst_ready,
    input logic [NB*8-1:0]  dst_data,
    input logic [NB-1:0]    dst_strb,
    input logic [LEN_W-1:0] src_left,
    input logic [OW-1:0]    occ
);
    // R1: quiet outputs right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!dst_valid && !src_ready));

    // R8: no reads once the byte budget is spent
    a_r8_no_read_after_end: assert property (@(posedge clk) disable iff (rst)
        (src_left == '0) |-> !src_ready);

    // R9: short strobe only once the source side is finished
    a_r9_short_only_last: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && ($countones(dst_strb) != NB)) |-> (src_left == '0));

    // R9: an offered beat always carries at least one byte
    a_r9_strb_nonempty: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (dst_strb != '0));

    // R10: stalled beat is held unchanged
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (dst_valid && !dst_ready && !start) |=>
            (dst_valid && $stable(dst_data) && $stable(dst_strb)));

    // R10: the byte queue never overflows
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(QD));
endmodule

bind dma_lane_packer dlp_checker #(
    .NB(NB), .QD(QD), .OW(OW), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .src_ready (src_ready),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_data  (dst_data),
    .dst_strb  (dst_strb),
    .src_left  (src_left),
    .occ       (occ)
);

// File: tb/dma_lane_packer_test.sv
module dma_lane_packer_test;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst, start;
    logic [1:0]  cfg_src_w, cfg_dst_w;
    logic        cfg_src_be, cfg_dst_be;
    logic [15:0] cfg_len;
    logic        src_valid, src_ready;
    logic [1:0]  src_addr;
    logic [31:0] src_data;
    logic        dst_valid, dst_ready;
    logic [31:0] dst_data;
    logic [3:0]  dst_strb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] strm [0:63];

    always #2.5 clk = ~clk;

    dma_lane_packer uut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_src_w(cfg_src_w), .cfg_dst_w(cfg_dst_w),
        .cfg_src_be(cfg_src_be), .cfg_dst_be(cfg_dst_be), .cfg_len(cfg_len),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_addr(src_addr), .src_data(src_data),
        .dst_valid(dst_valid), .dst_ready(dst_ready),
        .dst_data(dst_data), .dst_strb(dst_strb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] build_src(int si, int sw, int a0, bit sbe, int len);
        logic [31:0] d;
        d = $urandom;
        for (int k = 0; k < sw; k++) begin
            int idx, lane;
            idx = si * sw + k;
            lane = (a0 + idx) % 4;
            if (sbe) lane = 3 - lane;
            if (idx < len) d[lane*8 +: 8] = strm[idx];
        end
        return d;
    endfunction

    function automatic logic [31:0] exp_word(int base, int cnt, int dw, bit dbe);
        logic [31:0] v;
        v = 0;
        for (int j = 0; j < cnt; j++) begin
            int pos;
            pos = dbe ? dw - 1 - j : j;
            v = v | (32'(strm[base + j]) << (8 * pos));
        end
        if (dw == 1) v = {4{v[7:0]}};
        else if (dw == 2) v = {2{v[15:0]}};
        return v;
    endfunction

    function automatic logic [3:0] exp_mask(int cnt, int dw, bit dbe);
        logic [3:0] m;
        m = 0;
        for (int j = 0; j < cnt; j++) m[dbe ? dw - 1 - j : j] = 1'b1;
        if (dw == 1) m = {4{m[0]}};
        else if (dw == 2) m = {2{m[1:0]}};
        return m;
    endfunction

    function automatic logic [31:0] lane_mask(logic [3:0] s);
        logic [31:0] m;
        for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{s[l]}};
        return m;
    endfunction

    function automatic string tag_for(bit part, bit sbe, bit dbe, int a0, int dw);
        if (part) return "R9";
        if (dbe) return "R6";
        if (sbe) return "R4";
        if (a0 != 0) return "R3";
        if (dw < 4) return "R7";
        return "R5";
    endfunction

    task automatic run_xfer(input logic [1:0] sc, input logic [1:0] dc, input bit sbe,
                            input bit dbe, input int len, input int a_in, input bit pat);
        int sw, dw, a0, n_src, n_dst, si, di, cyc;
        bit was_stall;
        logic [31:0] held_d;
        logic [3:0]  held_s;
        sw = 1 << sc;
        dw = 1 << dc;
        a0 = a_in & ~(sw - 1);
        n_src = (len + sw - 1) / sw;
        n_dst = (len + dw - 1) / dw;
        si = 0; di = 0; cyc = 0; was_stall = 0;
        held_d = 0; held_s = 0;
        for (int i = 0; i < len; i++)
            strm[i] = pat ? 8'(8'h21 + 8'h22 * (i % 4)) : 8'($urandom);

        @(negedge clk);
        start = 1; cfg_src_w = sc; cfg_dst_w = dc;
        cfg_src_be = sbe; cfg_dst_be = dbe; cfg_len = 16'(len);
        src_valid = 0; dst_ready = 0;
        @(negedge clk);
        start = 0;
        // scramble configuration: must not matter now (R2)
        cfg_src_w = 2'($urandom); cfg_dst_w = 2'($urandom);
        cfg_src_be = 1'($urandom); cfg_dst_be = 1'($urandom);
        cfg_len = 16'($urandom);

        while ((si < n_src || di < n_dst) && cyc < 3000) begin
            src_valid = (si < n_src) && ($urandom % 4 != 0);
            src_addr  = 2'((a0 + si * sw) % 4);
            src_data  = build_src(si, sw, a0, sbe, len);
            dst_ready = ($urandom % 3 != 0);
            #1;
            if (was_stall) begin
                check("R10 hold valid", 32'(dst_valid), 32'd1);
                check("R10 hold data", dst_data, held_d);
                check("R10 hold strb", 32'(dst_strb), 32'(held_s));
            end
            if (dst_valid) begin
                if (di >= n_dst) begin
                    check("R8 extra beat", 32'(dst_valid), 32'd0);
                end else begin
                    int cnt;
                    bit part;
                    logic [3:0] em;
                    cnt = (len - di * dw < dw) ? len - di * dw : dw;
                    part = (cnt < dw);
                    em = exp_mask(cnt, dw, dbe);
                    check(tag_for(part, sbe, dbe, a0, dw), 32'(dst_strb), 32'(em));
                    check(tag_for(part, sbe, dbe, a0, dw), dst_data & lane_mask(em),
                          exp_word(di * dw, cnt, dw, dbe) & lane_mask(em));
                    if (dst_ready) di++;
                end
            end
            was_stall = dst_valid && !dst_ready;
            held_d = dst_data;
            held_s = dst_strb;
            if (src_valid && src_ready) si++;
            @(negedge clk);
            cyc++;
        end
        src_valid = 0;
        dst_ready = 0;
        #1;
        check("R8 ready low at end", 32'(src_ready), 32'd0);
        check("R8 no leftover beat", 32'(dst_valid), 32'd0);
        check("R2 beat count", 32'(di), 32'(n_dst));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; start = 0; cfg_src_w = 0; cfg_dst_w = 0;
        cfg_src_be = 0; cfg_dst_be = 0; cfg_len = 0;
        src_valid = 0; src_addr = 0; src_data = 0; dst_ready = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 dst_valid in reset", 32'(dst_valid), 32'd0);
        check("R1 src_ready in reset", 32'(src_ready), 32'd0);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        #1;
        check("R1 dst_valid after reset", 32'(dst_valid), 32'd0);
        check("R1 src_ready after reset", 32'(src_ready), 32'd0);

        // directed corners
        run_xfer(2'b00, 2'b10, 0, 0, 4, 0, 1);  // R5: 0x87654321
        run_xfer(2'b00, 2'b01, 0, 0, 4, 0, 1);  // R7: 0x43214321
        run_xfer(2'b00, 2'b00, 0, 0, 4, 0, 1);  // R7: 0x21212121
        run_xfer(2'b10, 2'b10, 0, 1, 4, 0, 1);  // R6: 0x21436587
        run_xfer(2'b01, 2'b00, 1, 0, 4, 0, 1);  // R4
        run_xfer(2'b00, 2'b00, 0, 0, 3, 2, 1);  // R3 offset lanes
        run_xfer(2'b00, 2'b10, 0, 0, 3, 0, 1);  // R9: strobe 0111
        run_xfer(2'b00, 2'b10, 0, 1, 3, 0, 1);  // R9: strobe 1110
        run_xfer(2'b00, 2'b01, 0, 0, 1, 0, 1);  // R9: strobe 0101
        run_xfer(2'b10, 2'b00, 0, 0, 6, 0, 1);  // R8: straddling last beat

        // constrained random mix
        for (int t = 0; t < 80; t++) begin
            run_xfer(2'($urandom % 3), 2'($urandom % 3), 1'($urandom), 1'($urandom),
                     1 + int'($urandom % 24), int'($urandom % 4), 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule